// File: doc/BRIEF.md
# Prescaled Dual Reload Timer Unit

This block produces periodic interrupt requests from two 8-bit reload timers. The timers share a single 8-bit prescaler. A free-running binary divider sits in front of the prescaler. It counts either a main clock enable or a sub clock enable, and a speed field picks which one. One of ten power-of-two taps of the divider, from /2 to /1024, supplies the prescaler's count pulses. Each prescaler underflow is one count pulse for both timers. Every stage counts down and reloads from its latch. Every stage therefore divides by its latch value plus one.

Software reaches the block through a simple write/read register port. It uses the port to set the control field, load the three latches, read the live count values and clear the interrupt flags. The whole block runs on one system clock. Every count event is a one-cycle enable.

Each counter is driven by a small state machine with two states. In state CNT_HALTED, a latch write also loads the counter. The transition *start* (run bit set) leads to CNT_RUNNING. In CNT_RUNNING, count pulses decrement the counter, and latch writes touch only the latch. The transition *stop* (run bit cleared) leads back to CNT_HALTED. The state register follows the run bit one cycle later.

Top module: `prescaled_reload_timers`

## Requirements
- R1: After reset, the control register, all latches, all counters and both interrupt flags read 0, and both `tmr_irq_o` bits are low.
- R2: The read port returns a value in the same cycle. The address map is:
  - address 0: control
  - address 1: prescaler count
  - address 2: timer 0 count
  - address 3: timer 1 count
  - address 4: flags, with timer 0 in bit 0 and timer 1 in bit 1
  - any other address: 0
- R3: Every counter decrements on each count pulse. A count pulse that arrives while the counter holds 0 is an underflow, and it reloads the latch value. A stage with latch value n therefore divides by n+1.
- R4: The control field bits [1:0] select the divider source. The values 00 and 01 select `main_ce`, and the values 10 and 11 select `sub_ce`.
- R5: The control field bits [5:2] give a tap index k. An index from 0 to 9 makes the prescaler pulse once every 2^(k+1) source pulses. The indices 10 to 15 act as 9.
- R6: Both timers count the underflows of the one prescaler. A timer with latch t therefore underflows every 2^(k+1)·(p+1)·(t+1) source pulses, where p is the prescaler latch.
- R7: Control bit 6 is the run bit. A latch write while the stage is halted also loads its counter. A latch write while the stage is running changes only the latch, and the new value takes effect at the next reload.
- R8: A timer underflow sets that timer's flag, which drives `tmr_irq_o`. Writing address 4 with a 0 in a flag's bit clears that flag, and a 1 leaves it unchanged. An underflow in the same cycle as a clear wins.
- R9: With the run bit at 0, the prescaler and both timers hold their counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ce | input | 1 | Main clock enable (one pulse per main clock period) |
| sub_ce | input | 1 | Sub clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| tmr_irq_o | output | 2 | Interrupt request flags of timer 0 and timer 1 |

## Verification
The hardest situation to reach from the ports is a latch write while a counter is running. The test must show that the live count stays put and that the new value only appears at the next reload. Count pulses normally arrive every few cycles, so a read could not tell an untouched count from a decremented one. The stimulus avoids this by selecting the sub source with `sub_ce` held low. The timers then run without receiving a single pulse. The test writes the latch, reads the count back unchanged, then switches to the main source and measures the new interrupt period. Periods are measured between two consecutive flag rises, each rise followed at once by a clear.

// File: rtl/prt_pkg.sv
package prt_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int N_TIMERS  = 2;
    localparam int DIV_TAPS  = 10;
    localparam int SEL_W     = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_PRE  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_TMR0 = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;

    localparam int CTRL_RUN_BIT = 6;

    typedef enum logic {
        CNT_HALTED  = 1'b0,
        CNT_RUNNING = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/prt_tap_divider.sv
module prt_tap_divider
    import prt_pkg::*;
#(
    parameter int TAPS = DIV_TAPS,
    parameter int SW   = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          main_ce_i,
    input  logic          sub_ce_i,
    input  logic [1:0]    speed_i,
    input  logic [SW-1:0] tap_sel_i,
    output logic          tick_o
);
    localparam logic [SW-1:0] LAST_TAP = SW'(TAPS - 1);

    logic            src_ce;
    logic [TAPS-1:0] div_q;
    logic [TAPS-1:0] tap_hit;
    logic [SW-1:0]   sel_eff;

    // speeds 10 and 11 use the sub clock, 00 and 01 the main clock
    assign src_ce = speed_i[1] ? sub_ce_i : main_ce_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (src_ce) div_q <= div_q + 1'b1;
    end

    // tap k fires when bit k is about to go from 0 to 1
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam logic [TAPS-1:0] LOW_ONES = TAPS'((1 << k) - 1);
        localparam logic [TAPS-1:0] WINDOW   = TAPS'((1 << (k + 1)) - 1);
        assign tap_hit[k] = src_ce && ((div_q & WINDOW) == LOW_ONES);
    end

    assign sel_eff = (tap_sel_i > LAST_TAP) ? LAST_TAP : tap_sel_i;
    assign tick_o  = tap_hit[sel_eff];

    // R4: a tick only ever comes from the selected source enable
    a_r4_tick_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (speed_i[1] ? sub_ce_i : main_ce_i));

    // R5: the /2 tap can never fire on two consecutive cycles
    a_r5_tap0_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && sel_eff == '0 && $stable(speed_i)) |=> !tick_o);
endmodule

// File: rtl/prt_reload_counter.sv
module prt_reload_counter
    import prt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         pulse_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o
);
    cnt_state_e   state_q, state_d;
    logic [W-1:0] cnt_q;
    logic [W-1:0] latch_q;
    logic         counting;
    logic         direct_load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_HALTED;
        else        state_q <= state_d;
    end

    // transitions: start / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALTED:  if (run_i)  state_d = CNT_RUNNING;
            CNT_RUNNING: if (!run_i) state_d = CNT_HALTED;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        counting    = 1'b0;
        direct_load = 1'b0;
        unique case (state_q)
            CNT_HALTED:  direct_load = wr_i;
            CNT_RUNNING: counting    = pulse_i;
        endcase
    end

    assign uf_o  = counting && (cnt_q == '0);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            cnt_q   <= '0;
        end else begin
            if (wr_i) latch_q <= wdata_i;
            if (direct_load)   cnt_q <= wdata_i;
            else if (uf_o)     cnt_q <= latch_q;
            else if (counting) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3: underflow reloads the value the latch held before the edge
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |=> (cnt_q == $past(latch_q)));

    // R3: a pulse on a non-zero count steps down by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && cnt_q != '0) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

    // R7: a latch write while running does not touch the count
    a_r7_run_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && state_q == CNT_RUNNING && !pulse_i) |=> $stable(cnt_q));

    // R9: without a pulse in the running state or a halted load the count holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !direct_load) |=> $stable(cnt_q));
endmodule

// File: rtl/prescaled_reload_timers.sv
module prescaled_reload_timers
    import prt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_ce,
    input  logic              sub_ce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_TIMERS-1:0] tmr_irq_o
);
    logic [DATA_W-1:0]   ctrl_q;
    logic                run;
    logic                tick;
    logic                pre_uf;
    logic [DATA_W-1:0]   pre_cnt;
    logic [DATA_W-1:0]   tmr_cnt [N_TIMERS];
    logic [N_TIMERS-1:0] tmr_uf;
    logic [N_TIMERS-1:0] flag_q;
    logic                flag_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data;
    end

    assign run     = ctrl_q[CTRL_RUN_BIT];
    assign flag_wr = wr_en && (wr_addr == ADDR_FLAG);

    prt_tap_divider #(.TAPS(DIV_TAPS), .SW(SEL_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_ce_i (main_ce),
        .sub_ce_i  (sub_ce),
        .speed_i   (ctrl_q[1:0]),
        .tap_sel_i (ctrl_q[5:2]),
        .tick_o    (tick)
    );

    prt_reload_counter #(.W(DATA_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .pulse_i (tick),
        .wr_i    (wr_en && wr_addr == ADDR_PRE),
        .wdata_i (wr_data),
        .cnt_o   (pre_cnt),
        .uf_o    (pre_uf)
    );

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_TMR0 + ADDR_W'(i);

        prt_reload_counter #(.W(DATA_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (run),
            .pulse_i (pre_uf),
            .wr_i    (wr_en && wr_addr == MY_ADDR),
            .wdata_i (wr_data),
            .cnt_o   (tmr_cnt[i]),
            .uf_o    (tmr_uf[i])
        );

        // underflow has priority over a software clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     flag_q[i] <= 1'b0;
            else if (tmr_uf[i])             flag_q[i] <= 1'b1;
            else if (flag_wr && !wr_data[i]) flag_q[i] <= 1'b0;
        end

        // R8: underflow sets the flag even against a clear
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_uf[i] |=> flag_q[i]);

        // R8: a clear without underflow drops the flag
        a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_wr && !wr_data[i] && !tmr_uf[i]) |=> !flag_q[i]);

        // R6: a timer only underflows on a prescaler underflow
        a_r6_shared_source: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_uf[i] |-> pre_uf);
    end

    assign tmr_irq_o = flag_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            3'd0:    rd_data = ctrl_q;
            3'd1:    rd_data = pre_cnt;
            3'd2:    rd_data = tmr_cnt[0];
            3'd3:    rd_data = tmr_cnt[1];
            3'd4:    rd_data = DATA_W'(flag_q);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: tb/prescaled_reload_timers_tb.sv
module prescaled_reload_timers_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_ce = 1'b1;
    logic       sub_ce = 1'b0;
    logic       sub_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] tmr_irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sub_cnt = 0;
    int exp_q[$];
    string tag_q[$];

    prescaled_reload_timers dut_i (
        .clk(clk), .rst_n(rst_n), .main_ce(main_ce), .sub_ce(sub_ce),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tmr_irq_o(tmr_irq_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // sub clock enable: one cycle in four
    always @(negedge clk) begin
        sub_cnt = (sub_cnt + 1) % 4;
        sub_ce  = sub_en && (sub_cnt == 0);
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at a negedge one cycle later
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: push expected period
    task automatic expect_period(input int p, input string tag);
        exp_q.push_back(p);
        tag_q.push_back(tag);
    endtask

    task automatic wait_rise(input int idx, output int t);
        int guard = 0;
        while (!tmr_irq_o[idx] && guard < 20000) begin
            @(negedge clk); guard++;
        end
        t = tmr_irq_o[idx] ? cyc : -100000;
    endtask

    // monitor: measure an interval and compare against the queue head
    task automatic measure(input int idx);
        int t0, t1, e;
        string tg;
        wr(3'd4, 8'h00);
        wait_rise(idx, t0);
        wr(3'd4, 8'h00);
        wait_rise(idx, t1);
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, t1 - t0, e);
    endtask

    // stop, load latches, set control with run
    task automatic setup(input logic [7:0] ctrl, input logic [7:0] p,
                         input logic [7:0] t0, input logic [7:0] t1);
        wr(3'd0, 8'h00);
        idle(2);
        wr(3'd1, p);
        wr(3'd2, t0);
        wr(3'd3, t1);
        wr(3'd0, ctrl);
        idle(2);
    endtask

    function automatic logic [7:0] mk_ctrl(input int run, input int tap, input int spd);
        return 8'((run << 6) | (tap << 2) | spd);
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, v2;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 0);
        end
        check("R1 irq after reset", int'(tmr_irq_o), 0);

        // R2 / R7 halted writes load counters; R2 unmapped address
        wr(3'd1, 8'd9);
        wr(3'd2, 8'd5);
        rd(3'd1, v); check("R7 halted write loads prescaler", v, 9);
        rd(3'd2, v); check("R7 halted write loads timer 0", v, 5);
        rd(3'd6, v); check("R2 unmapped address reads 0", v, 0);

        // R3/R6 main source, tap /2, prescaler 0
        setup(mk_ctrl(1, 0, 0), 8'd0, 8'd2, 8'd4);
        rd(3'd0, v); check("R2 control readback", v, int'(mk_ctrl(1, 0, 0)));
        expect_period(6, "R3 timer 0 period 2*1*3");
        expect_period(10, "R6 timer 1 period 2*1*5");
        measure(0);
        measure(1);

        // R9 halted counts hold
        wr(3'd0, mk_ctrl(0, 0, 0));
        idle(2);
        rd(3'd2, v); idle(30); rd(3'd2, v2);
        check("R9 timer 0 holds when halted", v2, v);
        rd(3'd1, v); idle(30); rd(3'd1, v2);
        check("R9 prescaler holds when halted", v2, v);

        // R8 flags: both set after the run above
        wr(3'd4, 8'h00);
        wr(3'd0, mk_ctrl(1, 0, 0));
        idle(40);
        wr(3'd0, mk_ctrl(0, 0, 0));
        idle(2);
        rd(3'd4, v); check("R8 both flags set", v, 3);
        wr(3'd4, 8'hFF);
        rd(3'd4, v); check("R8 writing 1 keeps flags", v, 3);
        wr(3'd4, 8'h02);
        check("R8 clear bit 0 only", int'(tmr_irq_o), 2);
        wr(3'd4, 8'h00);
        check("R8 clear both", int'(tmr_irq_o), 0);

        // R5 tap 3 (/16), prescaler 1, speed 01 still main (R4)
        setup(mk_ctrl(1, 3, 1), 8'd1, 8'd0, 8'd0);
        expect_period(32, "R5 tap 3 period 16*2*1");
        measure(0);

        // R5 tap index 12 acts as 9 (/1024), prescaler 0, timer 0
        setup(mk_ctrl(1, 12, 0), 8'd0, 8'd0, 8'd0);
        expect_period(1024, "R5 tap clamp to /1024");
        measure(0);

        // R4 sub source, speeds 10 and 11 (sub_ce every 4 cycles)
        setup(mk_ctrl(1, 0, 2), 8'd0, 8'd1, 8'd0);
        expect_period(16, "R4 speed 10 uses sub clock");
        measure(0);
        setup(mk_ctrl(1, 0, 3), 8'd0, 8'd1, 8'd0);
        expect_period(16, "R4 speed 11 uses sub clock");
        measure(0);

        // R7 running write: no pulses arrive (sub selected, sub_ce off)
        sub_en = 1'b0;
        setup(mk_ctrl(1, 0, 2), 8'd0, 8'd7, 8'd0);
        rd(3'd2, v); check("R7 halted load before run", v, 7);
        wr(3'd2, 8'd3);
        rd(3'd2, v); check("R7 running write leaves count", v, 7);
        wr(3'd0, mk_ctrl(1, 0, 0));
        expect_period(8, "R7 new latch used after reload 2*1*4");
        measure(0);
        sub_en = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule